// File: doc/BRIEF.md
# Contrast-Mapped Pair Recovery Unit

This block sits at the receiving end of a reversible watermark scheme that works on pairs of 8-bit gray pixels. Each incoming pair has either been contrast-mapped by the embedder (x' = 2x - y, y' = 2y - x) or left in place. The low bit of the first pixel tells the two cases apart. For a mapped pair the unit takes one payload bit from the low bit of the second pixel. It clears both low bits and inverts the mapping with a ceiling-rounded divide by three. For a pair left in place it puts back the first pixel's original low bit, which arrives on a separate side-information bit stream.

Pairs enter on a valid/ready stream. The side-information stream is drawn from only when the pair being accepted was left in place. Recovered pairs leave after a fixed two-cycle latency, at a rate of up to one pair per clock. Each recovered pair comes with an extracted-bit strobe that is raised only for mapped pairs. The divide uses a constant reciprocal multiply and a shift, so no iterative divider is needed.

Top module: `rcm_recover`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `out_valid` and `bit_valid` are low.
- R2: An accepted pair with `in_a[0] = 1` is a mapped pair. Its output has `bit_valid = 1` and `bit_out` equal to the received `in_b[0]`. A pair with `in_a[0] = 0` gives `bit_valid = 0`.
- R3: For a mapped pair, with a' = `in_a` and b' = `in_b`, each with bit 0 forced to 0, `out_a` = ceil((2a' + b') / 3).
- R4: For a mapped pair, `out_b` = ceil((2b' + a') / 3), with a' and b' cleared in the same way as in R3.
- R5: For a pair with `in_a[0] = 0`: `out_a[7:1]` equals `in_a[7:1]`, `out_a[0]` equals the `side_bit` taken with the pair, and `out_b` equals `in_b`.
- R6: `in_ready` = `in_a[0]` OR `side_valid`, and `side_ready` = `in_valid` AND NOT `in_a[0]`. A side bit is therefore consumed together with each accepted pair whose `in_a[0] = 0`, and with no other pair. For a mapped pair, `side_valid` and `side_bit` have no effect on the outputs.
- R7: A pair accepted on a clock edge appears on the outputs after the next edge, that is, two register stages later. Pairs can be accepted on consecutive edges, and `out_valid` is high only for accepted pairs, in order.
- R8: For a mapped pair whose values 2x - y or 2y - x were odd before the embedder overwrote their low bits, the output is still exactly (x, y). This includes pairs at the gray extremes 0 and 255.
- R9: When an embedder that maps in-range pairs that are not both odd (and passes every other pair with its first low bit moved to the side stream) feeds the unit, all 65536 pairs in the range 0..255 × 0..255 are restored exactly, and every embedded bit comes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Received pair is present |
| in_ready | output | 1 | Pair will be taken on this edge |
| in_a | input | 8 | First received pixel (bit 0 is the mapping marker) |
| in_b | input | 8 | Second received pixel (bit 0 carries payload on mapped pairs) |
| side_valid | input | 1 | Side-information bit is present |
| side_ready | output | 1 | Side bit is wanted by the current pair |
| side_bit | input | 1 | Original low bit of the first pixel for an unmapped pair |
| out_valid | output | 1 | Recovered pair is present |
| out_a | output | 8 | Recovered first pixel |
| out_b | output | 8 | Recovered second pixel |
| bit_valid | output | 1 | Extracted watermark bit is present |
| bit_out | output | 1 | Extracted watermark bit |

## Verification
The hardest case to reach is a mapped pair whose transformed values were odd, so that the embedder's marker or payload has destroyed information that the ceiling division must absorb. Random received pairs rarely show whether the original came back. The bench therefore carries its own embedder model and drives its output. It does this first for hand-picked pairs at the gray limits and then for every one of the 65536 pairs, so that every odd/even combination of the mapped values is reached. A second hard point is an unmapped pair that arrives while no side bit is offered. A directed step holds that pair with `side_valid` low, checks that it is not taken, and then shows that a mapped pair passes under the same conditions.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

    // Pair classification carried through the pipeline
    typedef enum logic {
        KIND_PLAIN  = 1'b0,
        KIND_MAPPED = 1'b1
    } pair_kind_e;

    // Smallest odd shift above the operand width; 2^odd + 1 divides by 3
    function automatic int odd_shift(input int w);
        return (((w + 1) % 2) == 1) ? (w + 1) : (w + 2);
    endfunction

    // Reciprocal of three scaled by 2^s, rounded up (exact when s is odd)
    function automatic longint recip3(input int s);
        return ((longint'(1) << s) + 1) / 3;
    endfunction

endpackage

// File: rtl/rcm_ceil_div3.sv
// ceil(num / 3) through a constant reciprocal multiply: floor((num + 2) * M >> SH)
module rcm_ceil_div3 #(
    parameter int IN_W  = 10,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  num,
    output logic [OUT_W-1:0] quo
);
    localparam int SH     = rcm_pkg::odd_shift(IN_W);
    localparam int MUL_W  = SH;
    localparam int PROD_W = IN_W + MUL_W;
    localparam logic [MUL_W-1:0] RECIP = MUL_W'(rcm_pkg::recip3(SH));

    logic [IN_W-1:0]   biased;
    logic [PROD_W-1:0] prod;

    always_comb begin
        biased = num + IN_W'(2);
        prod   = PROD_W'(biased) * PROD_W'(RECIP);
        quo    = OUT_W'(prod >> SH);
    end
endmodule

// File: rtl/rcm_classify.sv
// Splits a received pair into the operands for both recovery paths
module rcm_classify #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0]     pix_a,
    input  logic [PIX_W-1:0]     pix_b,
    input  logic                 side_bit,
    output rcm_pkg::pair_kind_e  kind,
    output logic                 payload,
    output logic [PIX_W-1:0]     op_a,
    output logic [PIX_W-1:0]     op_b,
    output logic [PIX_W-1:0]     keep_a,
    output logic [PIX_W-1:0]     keep_b
);
    localparam logic [PIX_W-1:0] LSB_CLR = ~PIX_W'(1);

    always_comb begin
        kind    = pix_a[0] ? rcm_pkg::KIND_MAPPED : rcm_pkg::KIND_PLAIN;
        payload = pix_b[0];
        op_a    = pix_a & LSB_CLR;
        op_b    = pix_b & LSB_CLR;
        keep_a  = {pix_a[PIX_W-1:1], side_bit};
        keep_b  = pix_b;
    end
endmodule

// File: rtl/rcm_accept.sv
// Joins the pair stream with the side-bit stream
module rcm_accept (
    input  logic in_valid,
    input  logic marker,
    input  logic side_valid,
    output logic in_ready,
    output logic side_ready,
    output logic take
);
    always_comb begin
        in_ready   = marker | side_valid;
        side_ready = in_valid & ~marker;
        take       = in_valid & in_ready;
    end
endmodule

// File: rtl/rcm_recover.sv
module rcm_recover
    import rcm_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_a,
    input  logic [PIX_W-1:0] in_b,
    input  logic             side_valid,
    output logic             side_ready,
    input  logic             side_bit,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_a,
    output logic [PIX_W-1:0] out_b,
    output logic             bit_valid,
    output logic             bit_out
);
    localparam int SUM_W = PIX_W + 2;
    localparam int LANES = 2;

    typedef struct packed {
        logic                        valid;
        pair_kind_e                  kind;
        logic                        payload;
        logic [LANES-1:0][SUM_W-1:0] sum;
        logic [PIX_W-1:0]            keep_a;
        logic [PIX_W-1:0]            keep_b;
    } mix_t;

    typedef struct packed {
        logic             valid;
        logic             bit_vld;
        logic             bit_val;
        logic [PIX_W-1:0] pa;
        logic [PIX_W-1:0] pb;
    } res_t;

    mix_t mix_d, mix_q;
    res_t res_d, res_q;

    logic             take;
    pair_kind_e       kind_c;
    logic             payload_c;
    logic [PIX_W-1:0] op_a, op_b, keep_a, keep_b;
    logic [SUM_W-1:0] lane_sum [LANES];
    logic [PIX_W-1:0] lane_q   [LANES];

    rcm_accept u_accept (
        .in_valid   (in_valid),
        .marker     (in_a[0]),
        .side_valid (side_valid),
        .in_ready   (in_ready),
        .side_ready (side_ready),
        .take       (take)
    );

    rcm_classify #(.PIX_W(PIX_W)) u_classify (
        .pix_a    (in_a),
        .pix_b    (in_b),
        .side_bit (side_bit),
        .kind     (kind_c),
        .payload  (payload_c),
        .op_a     (op_a),
        .op_b     (op_b),
        .keep_a   (keep_a),
        .keep_b   (keep_b)
    );

    // Lane 0 rebuilds the first pixel, lane 1 the second
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [PIX_W-1:0] prim, sec;
        assign prim        = (l == 0) ? op_a : op_b;
        assign sec         = (l == 0) ? op_b : op_a;
        assign lane_sum[l] = {1'b0, prim, 1'b0} + {2'b00, sec};

        rcm_ceil_div3 #(.IN_W(SUM_W), .OUT_W(PIX_W)) u_div (
            .num (mix_q.sum[l]),
            .quo (lane_q[l])
        );
    end

    always_comb begin
        mix_d       = mix_q;
        mix_d.valid = take;
        if (take) begin
            mix_d.kind    = kind_c;
            mix_d.payload = payload_c;
            mix_d.keep_a  = keep_a;
            mix_d.keep_b  = keep_b;
            for (int l = 0; l < LANES; l++) begin
                mix_d.sum[l] = lane_sum[l];
            end
        end

        res_d         = res_q;
        res_d.valid   = mix_q.valid;
        res_d.bit_vld = mix_q.valid && (mix_q.kind == KIND_MAPPED);
        if (mix_q.valid) begin
            if (mix_q.kind == KIND_MAPPED) begin
                res_d.pa      = lane_q[0];
                res_d.pb      = lane_q[1];
                res_d.bit_val = mix_q.payload;
            end else begin
                res_d.pa      = mix_q.keep_a;
                res_d.pb      = mix_q.keep_b;
                res_d.bit_val = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mix_q <= '0;
            res_q <= '0;
        end else begin
            mix_q <= mix_d;
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign out_a     = res_q.pa;
    assign out_b     = res_q.pb;
    assign bit_valid = res_q.bit_vld;
    assign bit_out   = res_q.bit_val;
endmodule

module rcm_recover_chk #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [PIX_W-1:0] in_a,
    input logic [PIX_W-1:0] in_b,
    input logic             side_valid,
    input logic             side_ready,
    input logic             side_bit,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_a,
    input logic [PIX_W-1:0] out_b,
    input logic             bit_valid,
    input logic             bit_out
);
    logic             acc_d1, acc_d2, side_d1, side_d2;
    logic [PIX_W-1:0] a_d1, a_d2, b_d1, b_d2;
    logic [PIX_W-1:0] ca, cb;
    logic [PIX_W+1:0] lhs_a, lhs_b, three_a, three_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_d1 <= 1'b0; acc_d2 <= 1'b0;
            side_d1 <= 1'b0; side_d2 <= 1'b0;
            a_d1 <= '0; a_d2 <= '0; b_d1 <= '0; b_d2 <= '0;
        end else begin
            acc_d1 <= in_valid && in_ready;
            acc_d2 <= acc_d1;
            side_d1 <= side_bit; side_d2 <= side_d1;
            a_d1 <= in_a; a_d2 <= a_d1;
            b_d1 <= in_b; b_d2 <= b_d1;
        end
    end

    always_comb begin
        ca      = {a_d2[PIX_W-1:1], 1'b0};
        cb      = {b_d2[PIX_W-1:1], 1'b0};
        lhs_a   = {1'b0, ca, 1'b0} + {2'b00, cb};
        lhs_b   = {1'b0, cb, 1'b0} + {2'b00, ca};
        three_a = {1'b0, out_a, 1'b0} + {2'b00, out_a};
        three_b = {1'b0, out_b, 1'b0} + {2'b00, out_b};
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> (!out_valid && !bit_valid));

    // R2
    bit_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && acc_d2) |-> (bit_valid == a_d2[0]) && (!a_d2[0] || bit_out == b_d2[0]));

    // R2
    bit_with_pair_chk: assert property (@(posedge clk) disable iff (!rst_n) bit_valid |-> out_valid);

    // R3
    first_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && a_d2[0]) |-> (three_a >= lhs_a) && ((three_a - lhs_a) <= 2));

    // R4
    second_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && a_d2[0]) |-> (three_b >= lhs_b) && ((three_b - lhs_b) <= 2));

    // R5
    plain_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !a_d2[0]) |-> (out_a == {a_d2[PIX_W-1:1], side_d2}) && (out_b == b_d2));

    // R6
    side_pairing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_a[0]) |-> (side_valid && side_ready));

    // R6
    side_demand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        side_ready |-> (in_valid && !in_a[0]));

    // R7
    latency_out_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> acc_d2);

    // R7
    latency_in_chk: assert property (@(posedge clk) disable iff (!rst_n) acc_d2 |-> out_valid);
endmodule

bind rcm_recover rcm_recover_chk #(.PIX_W(PIX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_a       (in_a),
    .in_b       (in_b),
    .side_valid (side_valid),
    .side_ready (side_ready),
    .side_bit   (side_bit),
    .out_valid  (out_valid),
    .out_a      (out_a),
    .out_b      (out_b),
    .bit_valid  (bit_valid),
    .bit_out    (bit_out)
);

// File: tb/tb_rcm_recover.sv
module tb_rcm_recover;
    localparam int W   = 8;
    localparam int MAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         side_valid = 1'b0;
    logic         side_ready;
    logic         side_bit = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_a, out_b;
    logic         bit_valid, bit_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    int    q_a[$], q_b[$], q_bv[$], q_bit[$], q_cyc[$];
    string q_tag[$];

    rcm_recover #(.PIX_W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
        .side_valid(side_valid), .side_ready(side_ready), .side_bit(side_bit),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b),
        .bit_valid(bit_valid), .bit_out(bit_out)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Output monitor: compares each recovered pair and its arrival cycle
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (q_a.size() == 0) begin
                    check(1'b0, "R7 output without accepted pair", int'(out_a), -1);
                end else begin
                    int ea, eb, ebv, ebit, ec;
                    int act, exp;
                    string tg;
                    ea = q_a.pop_front(); eb = q_b.pop_front(); ebv = q_bv.pop_front();
                    ebit = q_bit.pop_front(); ec = q_cyc.pop_front(); tg = q_tag.pop_front();
                    act = (int'(out_a) << 10) | (int'(out_b) << 2) | (int'(bit_valid) << 1)
                          | int'(bit_valid & bit_out);
                    exp = (ea << 10) | (eb << 2) | (ebv << 1) | (ebv & ebit);
                    check(act == exp, tg, act, exp);
                    check(cyc == ec + 2, "R7 latency", cyc - ec, 2);
                end
            end else if (q_cyc.size() != 0 && q_cyc[0] + 2 <= cyc) begin
                check(1'b0, "R7 missing output", 0, 1);
                void'(q_a.pop_front()); void'(q_b.pop_front()); void'(q_bv.pop_front());
                void'(q_bit.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
            end
        end
    end

    // Bench embedder model (mapping x' = 2x - y, y' = 2y - x)
    task automatic embed(input int x, input int y, input int bv,
                         output int a, output int b, output int side, output bit mapped);
        int xp, yp;
        xp = 2 * x - y;
        yp = 2 * y - x;
        if (xp >= 0 && xp <= MAX && yp >= 0 && yp <= MAX && !((x % 2 == 1) && (y % 2 == 1))) begin
            mapped = 1'b1; a = xp | 1; b = (yp & (MAX - 1)) | bv; side = 0;
        end else begin
            mapped = 1'b0; a = x & (MAX - 1); b = y; side = x & 1;
        end
    endtask

    task automatic send(input int a, input int b, input int side,
                        input int ea, input int eb, input int ebv, input int ebit, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_a = W'(a); in_b = W'(b);
        side_valid = 1'b1; side_bit = side[0];
        #1;
        if (in_ready) begin
            q_a.push_back(ea); q_b.push_back(eb); q_bv.push_back(ebv);
            q_bit.push_back(ebit); q_cyc.push_back(cyc); q_tag.push_back(tag);
        end else begin
            check(1'b0, "R6 pair refused with side bit offered", 0, 1);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; side_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        idle();
        repeat (4) @(negedge clk);
        check(q_a.size() == 0, tag, q_a.size(), 0);
    endtask

    task automatic test_reset();
        repeat (3) begin
            @(negedge clk);
            check(!out_valid && !bit_valid, "R1 outputs during reset", {out_valid, bit_valid}, 0);
        end
        rst_n = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check(!out_valid && !bit_valid, "R1 outputs after reset", {out_valid, bit_valid}, 0);
        end
    endtask

    task automatic mapped_one(input int a, input int b, input int side);
        int ca, cb;
        ca = a & (MAX - 1);
        cb = b & (MAX - 1);
        send(a, b, side, (2 * ca + cb + 2) / 3, (2 * cb + ca + 2) / 3, 1, b & 1,
             "R2 R3 R4 mapped pair");
    endtask

    task automatic test_mapped();
        mapped_one(155, 64, 0);
        mapped_one(1, 0, 1);
        mapped_one(255, 255, 0);
        mapped_one(1, 255, 1);
        mapped_one(255, 0, 1);
        mapped_one(87, 200, 0);
        mapped_one(133, 133, 1);
        drain("R7 mapped drain");
    endtask

    task automatic test_plain();
        send(0, 0, 1, 1, 0, 0, 0, "R5 plain pair");
        send(254, 17, 0, 254, 17, 0, 0, "R5 plain pair");
        send(100, 255, 1, 101, 255, 0, 0, "R5 plain pair");
        send(2, 3, 1, 3, 3, 0, 0, "R5 plain pair");
        drain("R7 plain drain");
    endtask

    task automatic test_handshake();
        @(negedge clk);
        in_valid = 1'b0; in_a = 8'd40; side_valid = 1'b0; #1;
        check(side_ready == 1'b0, "R6 side_ready without pair", side_ready, 0);
        @(negedge clk);
        in_valid = 1'b1; in_a = 8'd40; in_b = 8'd9; side_valid = 1'b0; #1;
        check(in_ready == 1'b0, "R6 plain pair held without side bit", in_ready, 0);
        check(side_ready == 1'b1, "R6 side bit requested", side_ready, 1);
        @(negedge clk);
        in_a = 8'd41; in_b = 8'd9; side_valid = 1'b0; side_bit = 1'b1; #1;
        check(in_ready == 1'b1, "R6 mapped pair needs no side bit", in_ready, 1);
        check(side_ready == 1'b0, "R6 mapped pair leaves side stream", side_ready, 0);
        q_a.push_back((2 * 40 + 8 + 2) / 3); q_b.push_back((2 * 8 + 40 + 2) / 3);
        q_bv.push_back(1); q_bit.push_back(1); q_cyc.push_back(cyc);
        q_tag.push_back("R6 mapped pair ignores side bit");
        drain("R7 handshake drain");
    endtask

    task automatic test_stream();
        for (int i = 0; i < 24; i++) begin
            int a, b;
            a = (i * 37 + 11) & MAX;
            b = (i * 91 + 5) & MAX;
            if (a % 2 == 1)
                send(a, b, i & 1, (2 * (a & 254) + (b & 254) + 2) / 3,
                     (2 * (b & 254) + (a & 254) + 2) / 3, 1, b & 1, "R7 stream mapped");
            else
                send(a, b, i & 1, a | (i & 1), b, 0, 0, "R7 stream plain");
            if (i % 3 == 2) idle();
        end
        drain("R7 stream drain");
    endtask

    task automatic test_corners();
        int xs[10] = '{0, 1, 2, 200, 170, 255, 128, 0, 85, 254};
        int ys[10] = '{0, 2, 1, 145, 85, 255, 128, 1, 170, 253};
        for (int i = 0; i < 10; i++) begin
            for (int bv = 0; bv < 2; bv++) begin
                int a, b, s;
                bit m;
                embed(xs[i], ys[i], bv, a, b, s, m);
                send(a, b, s, xs[i], ys[i], int'(m), bv, "R8 overwritten low bits");
            end
        end
        drain("R8 corner drain");
    endtask

    task automatic test_roundtrip();
        for (int x = 0; x <= MAX; x++) begin
            for (int y = 0; y <= MAX; y++) begin
                int a, b, s, bv;
                bit m;
                bv = (x ^ y ^ (x >> 3)) & 1;
                embed(x, y, bv, a, b, s, m);
                send(a, b, s, x, y, int'(m), bv, "R9 round trip");
            end
        end
        drain("R9 round trip drain");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        test_reset();
        test_mapped();
        test_plain();
        test_handshake();
        test_stream();
        test_corners();
        test_roundtrip();
        finish_run();
    end
endmodule